// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block brings a freshly inserted memory card from power-up to the data transfer state. It works through a command/response handshake and never touches the card lines itself. On a start pulse it reads three voltage capability bits and picks the highest supported supply. It drives a power-control code and selects the slow identification clock. After a warm-up interval it issues the card command sequence on its own.

The sequence is: go-idle, interface condition, the application-prefixed operating-condition probe (with a fallback to the MMC operating-condition command), readiness polling, CID read, relative address, CSD read and select. During the sequence the block records whether the card is an MMC and whether it is high capacity. At the end it switches to the fast data clock.

After identification the block also maps a logical block number to the address the card expects. The result is the block number itself for high-capacity cards and the block number times 512 otherwise. Poll spacing and the overall readiness timeout are counted in millisecond ticks from an input strobe.

Top module: `sd_card_init_seq`

## Requirements
- R1: After reset, cmd_req, done and error are 0, pwr_ctrl is 0x00 and clk_sel is 2'b00 (off).
- R2: On start, capability bit 2 (3.3 V) beats bit 1 (3.0 V), which beats bit 0 (1.8 V). pwr_ctrl becomes 0x0F, 0x0D or 0x0B respectively, and the OCR voltage bit is 20, 18 or 7. With no capability bit set, error rises with no command issued.
- R3: Throughout identification clk_sel is 2'b01 (slow). The first command waits at least WARM_MS ticks and is index 0 with argument 0.
- R4: Index 8 is sent with argument 0x1AA when the OCR bit position is 15 or above, and 0x2AA otherwise. Only an error-free response equal to that argument sets bit 30 in later readiness-poll arguments.
- R5: If the index-55 or index-41 probe fails, index 1 is tried with argument 0. On success the card is MMC (is_mmc=1): polls use index 1 with bit 30 set, index 3 carries 0x00010000, and rca is 1.
- R6: Readiness polling repeats (55 then 41 for SD, 1 for MMC) with argument bit30 OR the voltage bit. Polling stops when response bit 31 is 1, and is_hc takes response bit 30. Consecutive polls are separated by at least POLL_MS ticks.
- R7: If a busy poll response arrives after TIMEOUT_MS ticks of polling, error is raised.
- R8: For an SD card the command order is 0, 8, 55, 41, then the poll pairs, then 2, 3, 9, 7.
- R9: For SD, rca takes response bits 31:16 of index 3. Indices 9 and 7 carry argument {rca, 16'h0000}.
- R10: When index 7 completes without error, done is 1, clk_sel is 2'b10 (fast) and power stays on. done and error are never both 1.
- R11: An error response to index 0, a poll, or 2/3/9/7 (or to index 1 after a failed probe) raises error, sets pwr_ctrl to 0x00 and clk_sel to 2'b00, and no further command is issued.
- R12: cmd_index and cmd_arg stay stable while cmd_req is high without rsp_valid. cmd_req is low in the cycle after rsp_valid.
- R13: card_addr equals lba when is_hc is 1, and lba shifted left by 9 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new identification run (accepted when idle, done or failed) |
| cap_volt | input | 3 | Supply capability: bit2 3.3 V, bit1 3.0 V, bit0 1.8 V |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| cmd_req | output | 1 | Command request, held until rsp_valid |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response strobe for the pending command |
| rsp_err | input | 1 | Pending command failed |
| rsp_data | input | 32 | Short response payload |
| pwr_ctrl | output | 8 | Power-control code (voltage code OR bit 0 power-on) |
| clk_sel | output | 2 | 00 off, 01 identification clock, 10 data clock |
| done | output | 1 | Card reached transfer state |
| error | output | 1 | Sequence failed |
| is_mmc | output | 1 | Card answered as MMC |
| is_hc | output | 1 | Card is high capacity |
| rca | output | 16 | Relative card address |
| lba | input | 32 | Logical block number to map |
| card_addr | output | 32 | Address to send to the card for lba |

## Verification
A wrong step register shows at the ports as soon as the next command is requested, as an unexpected cmd_index or argument. The directed sequence logs therefore catch it within one command of the fault. A stale capacity-request flag or voltage position shows up in the first readiness-poll argument. A wrong MMC or capacity flag shows up in the index-3 argument, the final rca and card_addr. A missed error path leaves power on after error, which the power-off property flags on the very next cycle.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_WARM, S_CMD, S_GAP, S_DONE, S_ERR
    } seq_state_t;

    typedef enum logic [3:0] {
        K_GO_IDLE, K_IF_COND, K_PRB_APP, K_PRB_SD, K_PRB_MMC,
        K_POLL_APP, K_POLL_SD, K_POLL_MMC, K_CID, K_RCA, K_CSD, K_SEL
    } cmd_step_t;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'b00,
        CLK_SLOW = 2'b01,
        CLK_FAST = 2'b10
    } clk_sel_t;

    typedef struct packed {
        logic       ok;
        logic [4:0] ocr_pos;
        logic [7:0] pwr_code;
    } volt_pick_t;

    localparam logic [31:0] IFC_HIGH_V = 32'h0000_01AA;
    localparam logic [31:0] IFC_LOW_V  = 32'h0000_02AA;
    localparam logic [4:0]  LOW_V_LIMIT = 5'd15;
    localparam logic [31:0] MMC_RCA_ARG = 32'h0001_0000;

    function automatic logic [5:0] step_index(cmd_step_t s);
        case (s)
            K_GO_IDLE:             return 6'd0;
            K_IF_COND:             return 6'd8;
            K_PRB_APP, K_POLL_APP: return 6'd55;
            K_PRB_SD, K_POLL_SD:   return 6'd41;
            K_PRB_MMC, K_POLL_MMC: return 6'd1;
            K_CID:                 return 6'd2;
            K_RCA:                 return 6'd3;
            K_CSD:                 return 6'd9;
            default:               return 6'd7;
        endcase
    endfunction

endpackage

// File: rtl/sdinit_volt_sel.sv
module sdinit_volt_sel
    import sdinit_pkg::*;
(
    input  logic [2:0]  cap,
    output volt_pick_t  pick
);
    always_comb begin
        pick = '0;
        if (cap[2]) begin
            pick.ok = 1'b1; pick.ocr_pos = 5'd20; pick.pwr_code = 8'h0F;
        end else if (cap[1]) begin
            pick.ok = 1'b1; pick.ocr_pos = 5'd18; pick.pwr_code = 8'h0D;
        end else if (cap[0]) begin
            pick.ok = 1'b1; pick.ocr_pos = 5'd7;  pick.pwr_code = 8'h0B;
        end
    end
endmodule

// File: rtl/sdinit_tick_cnt.sv
module sdinit_tick_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (tick && (count != {W{1'b1}}))
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sdinit_addr_map.sv
module sdinit_addr_map #(
    parameter int AW    = 32,
    parameter int SHIFT = 9
) (
    input  logic          hc,
    input  logic [AW-1:0] lba,
    output logic [AW-1:0] addr
);
    always_comb addr = hc ? lba : (lba << SHIFT);
endmodule

// File: rtl/sd_card_init_seq.sv
module sd_card_init_seq
    import sdinit_pkg::*;
#(
    parameter int WARM_MS    = 1,
    parameter int POLL_MS    = 5,
    parameter int TIMEOUT_MS = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  cap_volt,
    input  logic        ms_tick,
    output logic        cmd_req,
    output logic [5:0]  cmd_index,
    output logic [31:0] cmd_arg,
    input  logic        rsp_valid,
    input  logic        rsp_err,
    input  logic [31:0] rsp_data,
    output logic [7:0]  pwr_ctrl,
    output logic [1:0]  clk_sel,
    output logic        done,
    output logic        error,
    output logic        is_mmc,
    output logic        is_hc,
    output logic [15:0] rca,
    input  logic [31:0] lba,
    output logic [31:0] card_addr
);
    localparam int GAP_MAX = (WARM_MS > POLL_MS) ? WARM_MS : POLL_MS;
    localparam int GAP_W   = $clog2(GAP_MAX + 2);
    localparam int TO_W    = $clog2(TIMEOUT_MS + 2);

    seq_state_t state_q;
    cmd_step_t  step_q, adv;
    clk_sel_t   clk_q;
    volt_pick_t pick;
    logic [4:0]  ocr_pos_q;
    logic [7:0]  pwr_q;
    logic        req_q, hcs_q, mmc_q, hc_q, done_q, err_q, poll_on_q;
    logic [15:0] rca_q;
    logic [GAP_W-1:0] gap_cnt;
    logic [TO_W-1:0]  to_cnt;
    logic [31:0] ocr_bit, if_arg, poll_arg;
    logic rsp_take, fatal, finish, to_gap, set_hcs, set_mmc, take_hc, take_rca;

    sdinit_volt_sel u_vsel (.cap(cap_volt), .pick(pick));

    sdinit_tick_cnt #(.W(GAP_W)) u_gap_cnt (
        .clk(clk), .rst(rst),
        .clr(!(state_q == S_WARM || state_q == S_GAP)),
        .tick(ms_tick), .count(gap_cnt)
    );

    sdinit_tick_cnt #(.W(TO_W)) u_to_cnt (
        .clk(clk), .rst(rst), .clr(!poll_on_q),
        .tick(ms_tick), .count(to_cnt)
    );

    sdinit_addr_map #(.AW(32), .SHIFT(9)) u_amap (
        .hc(hc_q), .lba(lba), .addr(card_addr)
    );

    assign ocr_bit  = 32'd1 << ocr_pos_q;
    assign if_arg   = (ocr_pos_q >= LOW_V_LIMIT) ? IFC_HIGH_V : IFC_LOW_V;
    assign poll_arg = {1'b0, hcs_q, 30'd0} | ocr_bit;
    assign rsp_take = (state_q == S_CMD) && req_q && rsp_valid;

    // Command presented on the handshake
    always_comb begin
        cmd_index = step_index(step_q);
        case (step_q)
            K_IF_COND:             cmd_arg = if_arg;
            K_POLL_SD, K_POLL_MMC: cmd_arg = poll_arg;
            K_RCA:                 cmd_arg = mmc_q ? MMC_RCA_ARG : 32'd0;
            K_CSD, K_SEL:          cmd_arg = {rca_q, 16'h0000};
            default:               cmd_arg = 32'd0;
        endcase
    end

    // Response decode per step
    always_comb begin
        adv = step_q; fatal = 1'b0; finish = 1'b0; to_gap = 1'b0;
        set_hcs = 1'b0; set_mmc = 1'b0; take_hc = 1'b0; take_rca = 1'b0;
        case (step_q)
            K_GO_IDLE: if (rsp_err) fatal = 1'b1; else adv = K_IF_COND;
            K_IF_COND: begin
                adv = K_PRB_APP;
                if (!rsp_err && rsp_data == if_arg) set_hcs = 1'b1;
            end
            K_PRB_APP: adv = rsp_err ? K_PRB_MMC : K_PRB_SD;
            K_PRB_SD:  adv = rsp_err ? K_PRB_MMC : K_POLL_APP;
            K_PRB_MMC: if (rsp_err) fatal = 1'b1;
                       else begin set_mmc = 1'b1; adv = K_POLL_MMC; end
            K_POLL_APP: if (rsp_err) fatal = 1'b1; else adv = K_POLL_SD;
            K_POLL_SD, K_POLL_MMC: begin
                if (rsp_err) fatal = 1'b1;
                else if (rsp_data[31]) begin take_hc = 1'b1; adv = K_CID; end
                else if (to_cnt >= TO_W'(TIMEOUT_MS)) fatal = 1'b1;
                else to_gap = 1'b1;
            end
            K_CID: if (rsp_err) fatal = 1'b1; else adv = K_RCA;
            K_RCA: if (rsp_err) fatal = 1'b1;
                   else begin take_rca = 1'b1; adv = K_CSD; end
            K_CSD: if (rsp_err) fatal = 1'b1; else adv = K_SEL;
            default: if (rsp_err) fatal = 1'b1; else finish = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;  step_q <= K_GO_IDLE; clk_q <= CLK_OFF;
            ocr_pos_q <= '0;    pwr_q <= '0;        req_q <= 1'b0;
            hcs_q <= 1'b0;      mmc_q <= 1'b0;      hc_q <= 1'b0;
            done_q <= 1'b0;     err_q <= 1'b0;      poll_on_q <= 1'b0;
            rca_q <= '0;
        end else begin
            case (state_q)
                S_IDLE, S_DONE, S_ERR: if (start) begin
                    step_q <= K_GO_IDLE; hcs_q <= 1'b0; mmc_q <= 1'b0;
                    hc_q <= 1'b0; rca_q <= '0; done_q <= 1'b0;
                    poll_on_q <= 1'b0;
                    if (pick.ok) begin
                        ocr_pos_q <= pick.ocr_pos; pwr_q <= pick.pwr_code;
                        clk_q <= CLK_SLOW; err_q <= 1'b0; state_q <= S_WARM;
                    end else begin
                        pwr_q <= '0; clk_q <= CLK_OFF; err_q <= 1'b1;
                        state_q <= S_ERR;
                    end
                end
                S_WARM: if (gap_cnt >= GAP_W'(WARM_MS)) state_q <= S_CMD;
                S_GAP: if (gap_cnt >= GAP_W'(POLL_MS)) begin
                    state_q <= S_CMD;
                    step_q  <= mmc_q ? K_POLL_MMC : K_POLL_APP;
                end
                S_CMD: if (rsp_take) begin
                    req_q <= 1'b0;
                    if (set_hcs) hcs_q <= 1'b1;
                    if (set_mmc) begin mmc_q <= 1'b1; hcs_q <= 1'b1; end
                    if (take_hc) hc_q <= rsp_data[30];
                    if (take_rca) rca_q <= mmc_q ? 16'd1 : rsp_data[31:16];
                    if (fatal) begin
                        pwr_q <= '0; clk_q <= CLK_OFF; err_q <= 1'b1;
                        state_q <= S_ERR;
                    end else if (finish) begin
                        clk_q <= CLK_FAST; done_q <= 1'b1; state_q <= S_DONE;
                    end else if (to_gap) begin
                        state_q <= S_GAP;
                    end else begin
                        step_q <= adv;
                        if (adv == K_POLL_APP || adv == K_POLL_MMC)
                            poll_on_q <= 1'b1;
                    end
                end else if (!req_q) begin
                    req_q <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cmd_req  = req_q;
    assign pwr_ctrl = pwr_q;
    assign clk_sel  = clk_q;
    assign done     = done_q;
    assign error    = err_q;
    assign is_mmc   = mmc_q;
    assign is_hc    = hc_q;
    assign rca      = rca_q;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !rsp_valid) |=> (cmd_req && $stable(cmd_index) && $stable(cmd_arg))); // R12
    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && rsp_valid) |=> !cmd_req); // R12
    AST_ERR_SAFE: assert property (@(posedge clk) disable iff (rst)
        error |-> (pwr_ctrl == 8'h00 && clk_sel == 2'b00 && !cmd_req)); // R11
    AST_DONE_FAST: assert property (@(posedge clk) disable iff (rst)
        done |-> (clk_sel == 2'b10 && pwr_ctrl[0])); // R10
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && error)); // R10
    AST_MMC_RCA: assert property (@(posedge clk) disable iff (rst)
        (done && is_mmc) |-> (rca == 16'd1)); // R5
endmodule

// File: tb/test_sd_card_init_seq.sv
module test_sd_card_init_seq;
    localparam int WARM = 1, POLL = 2, TOUT = 30, TICK_CYC = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst = 1'b1, start = 1'b0, ms_tick = 1'b0;
    logic [2:0] cap_volt = '0;
    logic cmd_req, rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [5:0] cmd_index;
    logic [31:0] cmd_arg, rsp_data = '0, lba = '0, card_addr;
    logic [7:0] pwr_ctrl;
    logic [1:0] clk_sel;
    logic done, error, is_mmc, is_hc;
    logic [15:0] rca;

    sd_card_init_seq #(.WARM_MS(WARM), .POLL_MS(POLL), .TIMEOUT_MS(TOUT)) i_sd_card_init_seq (
        .clk(clk), .rst(rst), .start(start), .cap_volt(cap_volt), .ms_tick(ms_tick),
        .cmd_req(cmd_req), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .pwr_ctrl(pwr_ctrl), .clk_sel(clk_sel), .done(done), .error(error),
        .is_mmc(is_mmc), .is_hc(is_hc), .rca(rca), .lba(lba), .card_addr(card_addr)
    );

    int n_checks = 0, n_fail = 0;
    int tick_total = 0;

    // card model configuration
    logic card_sd2 = 1'b0, card_mmc = 1'b0, card_hc = 1'b0;
    int   busy_n = 0, fail_idx = -1, op_cnt = 0;
    logic [15:0] card_rca = '0;

    // command log
    int          n_cmd = 0, hold_err = 0;
    int          log_idx [64];
    logic [31:0] log_arg [64];
    int          log_tick [64];
    logic [5:0]  r_idx;
    logic [31:0] r_arg, r_data;
    logic        r_err;

    logic [1:0] obs_clk;
    logic [7:0] obs_pwr;
    int         start_tick;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : ticker
        forever begin
            repeat (TICK_CYC - 1) @(negedge clk);
            ms_tick = 1'b1; tick_total++;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    end

    initial begin : responder
        forever begin
            @(negedge clk);
            if (!rst && cmd_req) begin
                r_idx = cmd_index; r_arg = cmd_arg;
                if (n_cmd < 64) begin
                    log_idx[n_cmd] = int'(r_idx); log_arg[n_cmd] = r_arg;
                    log_tick[n_cmd] = tick_total;
                end
                n_cmd++;
                repeat (2) begin
                    @(negedge clk);
                    if (!cmd_req || cmd_index !== r_idx || cmd_arg !== r_arg) hold_err++;
                end
                r_err = 1'b0; r_data = 32'h0000_0900;
                case (r_idx)
                    6'd8:  if (card_sd2) r_data = r_arg; else r_err = 1'b1;
                    6'd55: r_err = card_mmc;
                    6'd41, 6'd1: begin
                        if ((r_idx == 6'd1) != card_mmc) r_err = 1'b1;
                        else begin
                            op_cnt++;
                            r_data = {op_cnt > busy_n, card_hc & r_arg[30], 30'h00FF_8000};
                        end
                    end
                    6'd3:  r_data = {card_rca, 16'h0500};
                    default: ;
                endcase
                if (int'(r_idx) == fail_idx) r_err = 1'b1;
                rsp_valid = 1'b1; rsp_err = r_err; rsp_data = r_data;
                @(negedge clk);
                rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
            end
        end
    end

    task automatic setup_card(input logic sd2, input logic mmc, input logic hc,
                              input int busy, input logic [15:0] r, input int fidx);
        card_sd2 = sd2; card_mmc = mmc; card_hc = hc; busy_n = busy;
        card_rca = r; fail_idx = fidx; op_cnt = 0; n_cmd = 0;
    endtask

    task automatic run_seq(input logic [2:0] cap);
        int guard;
        @(negedge clk);
        cap_volt = cap; start_tick = tick_total; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (n_cmd == 0 && !done && !error && guard < 20000) begin
            @(negedge clk); guard++;
        end
        obs_clk = clk_sel; obs_pwr = pwr_ctrl;
        while (!done && !error && guard < 20000) begin
            @(negedge clk); guard++;
        end
        if (guard >= 20000) chk("run completion (R10/R11)", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 cmd_req", {31'd0, cmd_req}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 error", {31'd0, error}, 32'd0);
        chk("R1 pwr_ctrl", {24'd0, pwr_ctrl}, 32'd0);
        chk("R1 clk_sel", {30'd0, clk_sel}, 32'd0);
    endtask

    task automatic t_sd_hc;
        int exp_seq [12] = '{0, 8, 55, 41, 55, 41, 55, 41, 2, 3, 9, 7};
        setup_card(1'b1, 1'b0, 1'b1, 2, 16'h1234, -1);
        run_seq(3'b111);
        chk("R2 pwr 3.3V", {24'd0, obs_pwr}, 32'h0F);
        chk("R3 slow clock", {30'd0, obs_clk}, 32'd1);
        chk("R3 warm-up ticks", (log_tick[0] - start_tick >= WARM) ? 32'd1 : 32'd0, 32'd1);
        chk("R3 first arg", log_arg[0], 32'd0);
        chk("R8 command count", n_cmd, 32'd12);
        for (int i = 0; i < 12; i++) chk("R8 command order", log_idx[i], exp_seq[i]);
        chk("R4 if-cond arg", log_arg[1], 32'h1AA);
        chk("R6 poll arg", log_arg[5], 32'h4010_0000);
        chk("R6 poll spacing", (log_tick[6] - log_tick[5] >= POLL) ? 32'd1 : 32'd0, 32'd1);
        chk("R6 is_hc", {31'd0, is_hc}, 32'd1);
        chk("R9 rca", {16'd0, rca}, 32'h1234);
        chk("R9 csd arg", log_arg[10], 32'h1234_0000);
        chk("R9 select arg", log_arg[11], 32'h1234_0000);
        chk("R10 done", {31'd0, done}, 32'd1);
        chk("R10 fast clock", {30'd0, clk_sel}, 32'd2);
        chk("R10 power kept", {24'd0, pwr_ctrl}, 32'h0F);
        lba = 32'h0000_0ABC; @(negedge clk);
        chk("R13 hc address", card_addr, 32'h0000_0ABC);
    endtask

    task automatic t_sd_legacy;
        setup_card(1'b0, 1'b0, 1'b1, 0, 16'hBEEF, -1);
        run_seq(3'b001);
        chk("R2 pwr 1.8V", {24'd0, obs_pwr}, 32'h0B);
        chk("R4 low-voltage if-cond arg", log_arg[1], 32'h2AA);
        chk("R8 command count legacy", n_cmd, 32'd10);
        chk("R4 no capacity request", log_arg[5], 32'h0000_0080);
        chk("R6 is_hc legacy", {31'd0, is_hc}, 32'd0);
        chk("R9 rca legacy", {16'd0, rca}, 32'hBEEF);
        lba = 32'd3; @(negedge clk);
        chk("R13 byte address", card_addr, 32'h0000_0600);
    endtask

    task automatic t_mmc;
        setup_card(1'b0, 1'b1, 1'b1, 1, 16'h7777, -1);
        run_seq(3'b010);
        chk("R2 pwr 3.0V", {24'd0, obs_pwr}, 32'h0D);
        chk("R5 fallback index", log_idx[3], 32'd1);
        chk("R5 probe arg", log_arg[3], 32'd0);
        chk("R5 mmc poll arg", log_arg[4], 32'h4004_0000);
        chk("R5 is_mmc", {31'd0, is_mmc}, 32'd1);
        chk("R5 address arg", log_arg[6], 32'h0001_0000);
        chk("R5 rca fixed", {16'd0, rca}, 32'd1);
        chk("R5 csd arg", log_arg[7], 32'h0001_0000);
        chk("R10 mmc done", {31'd0, done}, 32'd1);
    endtask

    task automatic t_no_volt;
        setup_card(1'b1, 1'b0, 1'b0, 0, 16'h1, -1);
        run_seq(3'b000);
        chk("R2 no-volt error", {31'd0, error}, 32'd1);
        chk("R2 no-volt commands", n_cmd, 32'd0);
        chk("R2 no-volt power", {24'd0, pwr_ctrl}, 32'd0);
    endtask

    task automatic t_timeout;
        setup_card(1'b1, 1'b0, 1'b0, 100000, 16'h1, -1);
        run_seq(3'b100);
        chk("R7 timeout error", {31'd0, error}, 32'd1);
        chk("R7 last index", log_idx[n_cmd - 1], 32'd41);
        chk("R7 power off", {24'd0, pwr_ctrl}, 32'd0);
        chk("R7 clock off", {30'd0, clk_sel}, 32'd0);
    endtask

    task automatic t_cmd_fail;
        int seen;
        setup_card(1'b1, 1'b0, 1'b0, 0, 16'h0042, 9);
        run_seq(3'b100);
        chk("R11 error", {31'd0, error}, 32'd1);
        chk("R11 failing index", log_idx[n_cmd - 1], 32'd9);
        seen = n_cmd;
        repeat (50) @(negedge clk);
        chk("R11 no further command", n_cmd, seen);
        chk("R11 power off", {24'd0, pwr_ctrl}, 32'd0);
        chk("R11 clock off", {30'd0, clk_sel}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sd_hc();
        t_sd_legacy();
        t_mmc();
        t_no_volt();
        t_timeout();
        t_cmd_fail();
        chk("R12 handshake hold", hold_err, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule